// File: doc/BRIEF.md
# Master-Mode Audio Serial Transmitter

This block turns a stream of audio sample words into a framed serial stream. It is the master of the link, so it makes the bit clock and the word-select signal itself by dividing the system clock. Each frame holds two channel slots. Each slot is as many bit clocks long as the configured sample length, and the sample goes out MSB first. A set of static configuration pins selects the frame format, the sample length, how the two channels are packed in an input word, single-channel operation, left-justified timing and the output polarities.

Words arrive on a valid/ready input. The block takes a word only at the start of a slot that needs fresh data, and only for one system cycle at a time. The source must hold `in_valid` and `in_data` steady until it sees `in_ready` high on a rising clock edge. A word is transferred on any edge where both signals are high. If no word is offered when one is needed, that slot is sent as zeros and a sticky underflow flag is raised. A pause request lets the frame that is in flight finish, then stops all reads and raises `paused`. When the request is dropped, data flow resumes at the next frame start.

Top module: `i2s_tx_top`

## Requirements
- R1: `cfg_len_m1` is the sample length minus one. Codes 3 to 31 give 4 to 32 bits. With codes 0, 1 or 2 the block stays idle: no bit-clock edges and `in_ready` is never asserted.
- R2: Each channel slot lasts exactly L bit clocks (L = `cfg_len_m1`+1). It carries the L least significant bits of its channel value, MSB first. A frame is a left slot followed by a right slot, 2L bit clocks in all. `sd` changes on the falling internal bit clock and is stable at the rising edge.
- R3: For L of 16 or less, one word carries both channels: left in bits [15:0], right in bits [31:16]. For L above 16, each channel takes a whole word, and the left word is read before the right word.
- R4: With `cfg_swap` set and L of 16 or less, left is taken from bits [31:16] and right from bits [15:0]. For L above 16 (which includes everything above 24 bits) the swap bit has no effect.
- R5: With `cfg_mono` set, one word is read per frame. The left slot sends bits [15:0] (L of 16 or less) or the whole word (L above 16). The right slot sends zeros, and `cfg_swap` is ignored.
- R6: `cfg_fmt` picks the word-select shape before inversion. Let b be the bit index in the frame, starting at 0. Format 0: ws = (b >= L). Format 1: ws = (b < L), half of the frame. Format 2: ws = (b == 0), a one-bit pulse. Format 3: ws = (b < L), a pulse one slot long.
- R7: In format 0 with `cfg_ljust` clear, data lags word select by one bit: the left MSB goes out at b = 1, and the last right bit goes out at b = 0 of the next frame. With `cfg_ljust` set, and in every other format, the left MSB goes out at b = 0.
- R8: `cfg_sck_inv` inverts the `sck` pin and `cfg_ws_inv` inverts the `ws` pin.
- R9: After reset, and whenever `cfg_en` is low, `sck` = `cfg_sck_inv`, `ws` = `cfg_ws_inv`, and `sd`, `paused`, `underflow` and `in_ready` are all 0.
- R10: A pause request seen at a frame start stops reads and sends zeros for that frame. The frame already in progress finishes normally, and `paused` rises at the first frame start with the request present. After the request clears, the next frame start reads a word and `paused` falls.
- R11: A needed word that is not offered gives a zero slot and sets `underflow`. The flag stays set while enabled and clears when `cfg_en` goes low.
- R12: `in_ready` is high for single cycles, only at slot starts that need a word. Words are consumed in order, with no loss or repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Main enable |
| cfg_pause | input | 1 | Pause request |
| cfg_fmt | input | 2 | Frame format select |
| cfg_len_m1 | input | 5 | Sample length minus one |
| cfg_swap | input | 1 | Right channel in low half |
| cfg_mono | input | 1 | Single-channel framing |
| cfg_ljust | input | 1 | Remove one-bit delay in format 0 |
| cfg_sck_inv | input | 1 | Bit clock inversion |
| cfg_ws_inv | input | 1 | Word-select inversion |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word taken this cycle |
| in_data | input | 32 | Input sample word |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |
| paused | output | 1 | Pause in effect |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The bench uses HALF_DIV = 2, so one bit clock lasts four system cycles and a full 32-bit stereo frame plus its trailing bit fits in a few hundred cycles. That lets a single run cover every length class: the 4-bit minimum, packed 8 and 16 bits, unpacked 20 and 24 bits, the 32-bit maximum, and the invalid codes below 3. DATA_W stays at 32, so the packing threshold at 16 bits and the swap rule can be tested from both sides.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S      = 2'd0,
    FMT_DSP_HALF = 2'd1,
    FMT_DSP_BIT  = 2'd2,
    FMT_DSP_SLOT = 2'd3
  } fmt_e;

  // smallest legal length code (4-bit samples)
  localparam int unsigned LEN_MIN_CODE = 3;
endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick,
  output logic sck_i
);
  localparam int unsigned PERIOD = 2 * HALF_DIV;
  localparam int unsigned CW     = $clog2(PERIOD + 1);

  logic [CW-1:0] dcnt;

  // one tick per bit period: start of a new bit, bit clock falls
  assign tick = run && (dcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt  <= '0;
      sck_i <= 1'b0;
    end else if (!run) begin
      dcnt  <= '0;
      sck_i <= 1'b0;
    end else begin
      dcnt <= (dcnt == CW'(PERIOD - 1)) ? '0 : dcnt + 1'b1;
      if (dcnt == CW'(HALF_DIV))
        sck_i <= 1'b1;
      else if (dcnt == '0)
        sck_i <= 1'b0;
    end
  end
endmodule

// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer
  import i2s_tx_pkg::*;
#(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [LEN_W-1:0] len_m1,
  input  fmt_e             fmt,
  input  logic             ljust,
  output logic             ws_i,
  output logic             start_l,
  output logic             start_r
);
  localparam int unsigned PW = LEN_W + 1;

  logic [PW-1:0] bpos, last, slot, nxt, pos;
  logic          delay, ws_nxt;

  assign last  = {len_m1, 1'b1};            // 2L-1
  assign slot  = {1'b0, len_m1} + 1'b1;     // L
  assign nxt   = (bpos >= last) ? '0 : bpos + 1'b1;
  assign delay = (fmt == FMT_I2S) && !ljust;
  // data position inside the frame for the bit about to start
  assign pos   = delay ? ((nxt == '0) ? last : nxt - 1'b1) : nxt;

  always_comb begin
    case (fmt)
      FMT_I2S:      ws_nxt = (nxt >= slot);
      FMT_DSP_HALF: ws_nxt = (nxt < slot);
      FMT_DSP_BIT:  ws_nxt = (nxt == '0);
      FMT_DSP_SLOT: ws_nxt = (nxt < slot);
      default:      ws_nxt = 1'b0;
    endcase
  end

  assign start_l = tick && (pos == '0);
  assign start_r = tick && (pos == slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpos <= '1;
      ws_i <= 1'b0;
    end else if (!run) begin
      bpos <= last;
      ws_i <= 1'b0;
    end else if (tick) begin
      bpos <= nxt;
      ws_i <= ws_nxt;
    end
  end
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              start_l,
  input  logic              start_r,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              swap,
  input  logic              mono,
  input  logic              pause_req,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              sd,
  output logic              paused,
  output logic              underflow
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned PW     = LEN_W + 1;

  logic [DATA_W-1:0] sreg, word, left_val, right_val, load_val, aligned;
  logic [HALF_W-1:0] hold_q, right_pk, lo, hi;
  logic [PW-1:0]     slot, shamt;
  logic              packed_mode, rd_l, rd_r, paused_q, underflow_q;

  assign slot        = {1'b0, len_m1} + 1'b1;
  assign shamt       = PW'(DATA_W) - slot;
  assign packed_mode = (len_m1 < LEN_W'(HALF_W));
  assign rd_l        = start_l && !pause_req;
  assign rd_r        = start_r && !paused_q && !packed_mode && !mono;
  assign in_ready    = run && (rd_l || rd_r);

  assign word = in_valid ? in_data : '0;
  assign lo   = word[HALF_W-1:0];
  assign hi   = word[DATA_W-1:HALF_W];

  always_comb begin
    if (!rd_l)
      left_val = '0;
    else if (!packed_mode)
      left_val = word;
    else if (swap && !mono)
      left_val = {{HALF_W{1'b0}}, hi};
    else
      left_val = {{HALF_W{1'b0}}, lo};
  end

  assign right_pk  = (mono || !rd_l) ? '0 : (swap ? lo : hi);
  assign right_val = packed_mode ? {{HALF_W{1'b0}}, hold_q} : (rd_r ? word : '0);
  assign load_val  = start_l ? left_val : right_val;
  assign aligned   = load_val << shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg        <= '0;
      sd          <= 1'b0;
      hold_q      <= '0;
      paused_q    <= 1'b0;
      underflow_q <= 1'b0;
    end else if (!run) begin
      sreg        <= '0;
      sd          <= 1'b0;
      hold_q      <= '0;
      paused_q    <= 1'b0;
      underflow_q <= 1'b0;
    end else begin
      if (start_l || start_r) begin
        sd   <= aligned[DATA_W-1];
        sreg <= aligned << 1;
      end else if (tick) begin
        sd   <= sreg[DATA_W-1];
        sreg <= sreg << 1;
      end
      if (start_l) begin
        paused_q <= pause_req;
        hold_q   <= right_pk;
      end
      if ((rd_l || rd_r) && !in_valid)
        underflow_q <= 1'b1;
    end
  end

  assign paused    = paused_q;
  assign underflow = underflow_q;
endmodule

// File: rtl/i2s_tx_top.sv
module i2s_tx_top
  import i2s_tx_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_en,
  input  logic                       cfg_pause,
  input  logic [1:0]                 cfg_fmt,
  input  logic [$clog2(DATA_W)-1:0]  cfg_len_m1,
  input  logic                       cfg_swap,
  input  logic                       cfg_mono,
  input  logic                       cfg_ljust,
  input  logic                       cfg_sck_inv,
  input  logic                       cfg_ws_inv,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DATA_W-1:0]          in_data,
  output logic                       sck,
  output logic                       ws,
  output logic                       sd,
  output logic                       paused,
  output logic                       underflow
);
  localparam int unsigned LEN_W = $clog2(DATA_W);

  logic run, tick, sck_i, ws_i, start_l, start_r;

  assign run = cfg_en && (cfg_len_m1 >= LEN_W'(LEN_MIN_CODE));

  i2s_tx_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick),
    .sck_i (sck_i)
  );

  i2s_tx_framer #(.LEN_W(LEN_W)) u_frm (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (tick),
    .len_m1  (cfg_len_m1),
    .fmt     (fmt_e'(cfg_fmt)),
    .ljust   (cfg_ljust),
    .ws_i    (ws_i),
    .start_l (start_l),
    .start_r (start_r)
  );

  i2s_tx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .start_l   (start_l),
    .start_r   (start_r),
    .len_m1    (cfg_len_m1),
    .swap      (cfg_swap),
    .mono      (cfg_mono),
    .pause_req (cfg_pause),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .sd        (sd),
    .paused    (paused),
    .underflow (underflow)
  );

  assign sck = sck_i ^ cfg_sck_inv;
  assign ws  = ws_i ^ cfg_ws_inv;
endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk #(
  parameter int unsigned LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_pause,
  input logic [LEN_W-1:0] cfg_len_m1,
  input logic             cfg_sck_inv,
  input logic             cfg_ws_inv,
  input logic             in_valid,
  input logic             in_ready,
  input logic             sck,
  input logic             ws,
  input logic             sd,
  input logic             paused,
  input logic             underflow
);
  AST_BAD_LEN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_len_m1 < LEN_W'(3)) |-> !in_ready); // R1

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (sck == cfg_sck_inv && ws == cfg_ws_inv && !sd && !paused && !underflow)); // R9

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R12

  AST_NO_READ_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && cfg_pause) |-> !in_ready); // R10

  AST_PAUSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> $past(cfg_pause)); // R10

  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && cfg_en) |=> underflow); // R11

  AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> $past(in_ready && !in_valid)); // R11
endmodule

bind i2s_tx_top i2s_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_en      (cfg_en),
  .cfg_pause   (cfg_pause),
  .cfg_len_m1  (cfg_len_m1),
  .cfg_sck_inv (cfg_sck_inv),
  .cfg_ws_inv  (cfg_ws_inv),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .sck         (sck),
  .ws          (ws),
  .sd          (sd),
  .paused      (paused),
  .underflow   (underflow)
);

// File: tb/i2s_tx_top_tb.sv
`timescale 1ns/1ps
module i2s_tx_top_tb;
  typedef struct packed {
    logic [1:0]  fmt;
    logic [4:0]  lm1;
    logic        swap;
    logic        mono;
    logic        lj;
    logic [31:0] w0, w1, w2, w3;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd15, 1'b0, 1'b0, 1'b0, 32'h1234ABCD, 32'h80017FFE, 32'hF0F00F0F, 32'h5555AAAA},
    '{2'd0, 5'd15, 1'b1, 1'b0, 1'b0, 32'h1234ABCD, 32'h80017FFE, 32'hF0F00F0F, 32'h5555AAAA},
    '{2'd0, 5'd7,  1'b0, 1'b0, 1'b1, 32'h00C3005A, 32'h00810018, 32'h00FF0001, 32'h00110022},
    '{2'd1, 5'd31, 1'b0, 1'b0, 1'b0, 32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'h76543210},
    '{2'd2, 5'd23, 1'b1, 1'b0, 1'b0, 32'h00ABCDEF, 32'h00123456, 32'h00FEDCBA, 32'h00654321},
    '{2'd3, 5'd3,  1'b0, 1'b0, 1'b0, 32'h00090006, 32'h000C0003, 32'h000A0005, 32'h000F0001},
    '{2'd0, 5'd15, 1'b1, 1'b1, 1'b0, 32'h1234ABCD, 32'h80017FFE, 32'hF0F00F0F, 32'h5555AAAA},
    '{2'd2, 5'd19, 1'b0, 1'b1, 1'b0, 32'h000ABCDE, 32'h00012345, 32'h000F0F0F, 32'h00070707}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_en = 0, cfg_pause = 0, cfg_swap = 0, cfg_mono = 0, cfg_ljust = 0;
  logic        cfg_sck_inv = 0, cfg_ws_inv = 0;
  logic [1:0]  cfg_fmt = 0;
  logic [4:0]  cfg_len_m1 = 5'd15;
  logic        in_valid = 0;
  logic [31:0] in_data = 0;
  logic        in_ready, sck, ws, sd, paused, underflow;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  i2s_tx_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_pause(cfg_pause),
    .cfg_fmt(cfg_fmt), .cfg_len_m1(cfg_len_m1), .cfg_swap(cfg_swap),
    .cfg_mono(cfg_mono), .cfg_ljust(cfg_ljust), .cfg_sck_inv(cfg_sck_inv),
    .cfg_ws_inv(cfg_ws_inv), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .sck(sck), .ws(ws), .sd(sd), .paused(paused),
    .underflow(underflow)
  );

  // word source: holds a word until it is taken
  logic [31:0] fw [4];
  int  fidx = 0;
  bit  feed_on = 0, pend = 0;
  initial forever begin
    @(negedge clk); #1;
    if (pend) begin fidx++; pend = 0; end
    in_valid = feed_on && (fidx < 4);
    in_data  = (fidx < 4) ? fw[fidx] : 32'h0;
    if (in_valid && in_ready) pend = 1;
  end

  // capture ws/sd at each rising (de-inverted) bit clock
  bit cap_ws [160];
  bit cap_sd [160];
  int cap_n = 0;
  bit cap_on = 0, pol_s = 0, prev_s = 0;
  initial forever begin
    bit cur;
    @(negedge clk); #1;
    cur = sck ^ pol_s;
    if (cap_on && cur && !prev_s && cap_n < 160) begin
      cap_ws[cap_n] = ws;
      cap_sd[cap_n] = sd;
      cap_n++;
    end
    prev_s = cur;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_bits(int n);
    int t = 0;
    while (cap_n < n && t < 5000) begin @(negedge clk); t++; end
  endtask

  function automatic logic [31:0] wsel(vec_t v, int i);
    case (i)
      0: return v.w0;
      1: return v.w1;
      2: return v.w2;
      3: return v.w3;
      default: return 32'h0;
    endcase
  endfunction

  // expected channel value from the packing rules (R3, R4, R5)
  function automatic logic [31:0] m_slot(vec_t v, int fr, int s);
    int L = int'(v.lm1) + 1;
    logic [31:0] w;
    if (L <= 16) begin
      w = wsel(v, fr);
      if (v.mono) return (s != 0) ? 32'h0 : {16'h0, w[15:0]};
      if (v.swap) return (s != 0) ? {16'h0, w[15:0]} : {16'h0, w[31:16]};
      return (s != 0) ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    end
    if (v.mono) return (s != 0) ? 32'h0 : wsel(v, fr);
    return wsel(v, 2 * fr + s);
  endfunction

  function automatic bit m_ws(vec_t v, int b);
    int L = int'(v.lm1) + 1;
    case (v.fmt)
      2'd0: return b >= L;
      2'd2: return b == 0;
      default: return b < L;
    endcase
  endfunction

  function automatic bit m_sd(vec_t v, int k);
    int L = int'(v.lm1) + 1;
    int fl = 2 * L;
    int b = k % fl;
    int fr = k / fl;
    int p;
    logic [31:0] val;
    if (v.fmt == 2'd0 && !v.lj) begin
      if (b == 0) begin
        if (fr == 0) return 1'b0;
        fr--;
        p = fl - 1;
      end else p = b - 1;
    end else p = b;
    val = m_slot(v, fr, (p >= L) ? 1 : 0);
    return val[L - 1 - (p % L)];
  endfunction

  function automatic string vtag(int i);
    case (i)
      0: return "R2 R3 R6 R7";
      1: return "R4";
      2: return "R7";
      3: return "R3 R6 R12";
      4: return "R4 R6";
      5: return "R2 R6";
      6: return "R5";
      default: return "R5 R6";
    endcase
  endfunction

  task automatic setup(vec_t v, bit feed);
    @(negedge clk);
    cfg_en = 0; cfg_pause = 0;
    cfg_fmt = v.fmt; cfg_len_m1 = v.lm1; cfg_swap = v.swap;
    cfg_mono = v.mono; cfg_ljust = v.lj;
    fw[0] = v.w0; fw[1] = v.w1; fw[2] = v.w2; fw[3] = v.w3;
    repeat (2) @(negedge clk);
    fidx = 0; pend = 0; feed_on = feed; cap_n = 0; cap_on = 1;
    @(negedge clk);
    cfg_en = 1;
  endtask

  task automatic finish_run();
    @(negedge clk);
    cfg_en = 0; cap_on = 0; feed_on = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(vec_t v, int nbits, string tag, int id);
    int bad_ws = -1, bad_sd = -1;
    for (int k = 0; k < nbits; k++) begin
      int b = k % (2 * (int'(v.lm1) + 1));
      if (bad_ws < 0 && cap_ws[k] != m_ws(v, b)) bad_ws = k;
      if (bad_sd < 0 && cap_sd[k] != m_sd(v, k)) bad_sd = k;
    end
    check(cap_n >= nbits && bad_ws < 0, tag, $sformatf("vec %0d ws bit %0d", id, bad_ws),
          (bad_ws < 0) ? cap_n : cap_ws[bad_ws], (bad_ws < 0) ? nbits : m_ws(v, bad_ws % (2 * (int'(v.lm1) + 1))));
    check(cap_n >= nbits && bad_sd < 0, tag, $sformatf("vec %0d sd bit %0d", id, bad_sd),
          (bad_sd < 0) ? cap_n : cap_sd[bad_sd], (bad_sd < 0) ? nbits : m_sd(v, bad_sd));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    vec_t v;
    // R9: reset state
    repeat (3) @(negedge clk);
    check(!sck && !ws && !sd && !paused && !underflow && !in_ready, "R9", "reset outputs",
          {sck, ws, sd, paused, underflow, in_ready}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // table walk: framing, packing, swap, mono, formats, delay
    for (int i = 0; i < NV; i++) begin
      int L = int'(VECS[i].lm1) + 1;
      setup(VECS[i], 1'b1);
      wait_bits(4 * L + 1);
      compare(VECS[i], 4 * L + 1, vtag(i), i);
      finish_run();
    end

    // R1: invalid length code keeps the block idle
    begin
      int edges = 0, rdy = 0;
      v = VECS[0];
      v.lm1 = 5'd2;
      setup(v, 1'b1);
      for (int c = 0; c < 60; c++) begin
        @(negedge clk); #1;
        if (sck) edges++;
        if (in_ready) rdy++;
      end
      check(edges == 0 && rdy == 0, "R1", "code 2 clock/ready activity", edges + rdy, 0);
      finish_run();
    end

    // R11: underflow gives zeros, sticky, cleared by disable
    begin
      int ones = 0;
      setup(VECS[0], 1'b0);
      wait_bits(33);
      for (int k = 0; k < 33; k++) if (cap_sd[k]) ones++;
      check(ones == 0, "R11", "sd ones during underflow", ones, 0);
      check(underflow == 1'b1, "R11", "underflow flag set", underflow, 1);
      finish_run();
      check(underflow == 1'b0, "R11", "underflow cleared by disable", underflow, 0);
    end

    // R10: pause finishes the frame, zeros afterwards, resumes at frame start
    begin
      int t = 0;
      v = '{2'd2, 5'd7, 1'b0, 1'b0, 1'b0, 32'h00C3005A, 32'h00FF00FF, 32'h00110022, 32'h00330044};
      setup(v, 1'b1);
      while (fidx < 1 && t < 2000) begin @(negedge clk); t++; end
      cfg_pause = 1;
      wait_bits(32);
      v.w1 = 32'h0;  // paused frame must be silent
      compare(v, 32, "R10", 99);
      check(paused == 1'b1, "R10", "paused flag", paused, 1);
      check(fidx == 1, "R10", "words taken while paused", fidx, 1);
      @(negedge clk);
      cfg_pause = 0;
      t = 0;
      while (t < 2000) begin
        @(negedge clk); #1;
        if (in_ready) break;
        t++;
      end
      @(negedge clk); #1;
      check(ws == 1'b1 && paused == 1'b0, "R10", "resume at frame start (ws,paused)",
            {ws, paused}, 2'b10);
      finish_run();
    end

    // R8: polarity inversion, idle and running
    begin
      @(negedge clk);
      cfg_sck_inv = 1; cfg_ws_inv = 1; pol_s = 1;
      repeat (2) @(negedge clk); #1;
      check(sck == 1'b1 && ws == 1'b1 && sd == 1'b0, "R8", "inverted idle levels",
            {sck, ws, sd}, 3'b110);
      v = VECS[5];
      v.fmt = 2'd2;
      setup(v, 1'b1);
      wait_bits(8);
      check(cap_ws[0] == 1'b0 && cap_ws[1] && cap_ws[4] && cap_ws[7], "R8", "inverted ws pulse",
            {cap_ws[0], cap_ws[1], cap_ws[4], cap_ws[7]}, 4'b0111);
      finish_run();
      cfg_sck_inv = 0; cfg_ws_inv = 0; pol_s = 0;
    end

    summary();
    $finish;
  end
endmodule